// File: doc/BRIEF.md
# Sequential Turn Signal Controller

This block is a Moore state machine that drives two groups of three indicator lamps, one group on the left and one on the right. When the machine is idle with all lamps dark and a direction request is present, it steps that side through a cumulative pattern, one step per clock. The first step lights lamp A alone. The second lights A and B. The third lights A, B and C. On the next clock all lamps go dark again.

A sequence that has started always runs to the end, even if the request is dropped partway through. If the request is still held when the machine returns to the dark state, the pattern starts again. Left takes priority when both requests arrive together. The clock is expected to run slowly, near 1 Hz. Debouncing and pin mapping are left to the surrounding logic.

Top module: `turn_signal_ctrl`

## Requirements
- R1: A synchronous, active-high reset puts the machine in the dark state, with all six lamps low on the next edge. Reset overrides every transition, including one in the middle of a sequence.
- R2: In the dark state with neither request asserted, the machine stays dark and all lamps remain low.
- R3: A left request sampled in the dark state gives, on the following three clocks, left lamp vector {C,B,A} = 3'b001, then 3'b011, then 3'b111. The right lamps stay 3'b000 throughout. On the clock after that, all lamps are dark.
- R4: A right request sampled in the dark state gives the same pattern 3'b001, 3'b011, 3'b111 on the right lamps {C,B,A}. The left lamps stay 3'b000 throughout. On the clock after that, all lamps are dark.
- R5: Once a sequence has started, it completes whatever happens on the request inputs. Inputs are sampled only in the dark state, so the opposite side cannot interrupt a running sequence.
- R6: If a request is still asserted when the machine is in the dark state, the next sequence starts on the following clock. A held request therefore repeats with a period of four clocks, with one dark clock between sequences.
- R7: When both requests are asserted in the dark state, the left sequence runs and the right request is ignored.
- R8: The lamps depend only on the state. A change on the inputs does not change the lamps before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous reset, active high |
| reqLeft | input | 1 | Left sequence request |
| reqRight | input | 1 | Right sequence request |
| lampLeft | output | 3 | Left lamps {C,B,A} |
| lampRight | output | 3 | Right lamps {C,B,A} |

## Verification
Every lamp vector is registered. A request sampled at an edge in the dark state therefore shows its first lamp just after that edge. The next two steps follow one edge each, and the dark state follows one edge after the third step. The driver task drives the request inputs between edges. After every edge it pushes the vector it expects, derived from the requirements, into a queue. The monitor pops one entry per cycle at the falling edge, half a period after the update, so every sample lands in the cycle in which its result is due. Reset midway through a sequence is expected to give a dark vector on the very next edge.

// File: rtl/turn_signal_pkg.sv
package turn_signal_pkg;
  localparam int LAMPS = 3;
  localparam int STEPS = LAMPS;
  localparam int CNT_W = $clog2(STEPS + 1);

  typedef enum logic [1:0] {SIDE_NONE = 2'd0, SIDE_LEFT = 2'd1, SIDE_RIGHT = 2'd2} side_e;

  typedef struct packed {
    logic  load;
    side_e side;
  } ctrl_strobe_t;
endpackage

// File: rtl/turn_signal_ctrl_fsm.sv
module turn_signal_ctrl_fsm
  import turn_signal_pkg::*;
#(
  parameter int STEP_COUNT = STEPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqLeft,
  input  logic         reqRight,
  output ctrl_strobe_t strobe,
  output logic [$clog2(STEP_COUNT+1)-1:0] stepIdx
);
  localparam int W = $clog2(STEP_COUNT + 1);

  side_e         sideQ, sideD;
  logic [W-1:0]  stepQ, stepD;

  always_comb begin
    sideD         = sideQ;
    stepD         = stepQ;
    strobe.load   = 1'b0;
    strobe.side   = SIDE_NONE;
    if (sideQ == SIDE_NONE) begin
      if (reqLeft) begin
        sideD = SIDE_LEFT;
        stepD = W'(1);
      end else if (reqRight) begin
        sideD = SIDE_RIGHT;
        stepD = W'(1);
      end
    end else if (stepQ == W'(STEP_COUNT)) begin
      sideD = SIDE_NONE;
      stepD = '0;
    end else begin
      stepD = stepQ + W'(1);
    end
    strobe.load = 1'b1;
    strobe.side = sideD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sideQ <= SIDE_NONE;
      stepQ <= '0;
    end else begin
      sideQ <= sideD;
      stepQ <= stepD;
    end
  end

  assign stepIdx = stepD;
endmodule

// File: rtl/turn_signal_lamp_dp.sv
module turn_signal_lamp_dp
  import turn_signal_pkg::*;
#(
  parameter int LAMP_COUNT = LAMPS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctrl_strobe_t                   strobe,
  input  logic [$clog2(LAMP_COUNT+1)-1:0] stepIdx,
  output logic [LAMP_COUNT-1:0]          lampLeft,
  output logic [LAMP_COUNT-1:0]          lampRight
);
  logic [LAMP_COUNT-1:0] thermo;

  genvar g;
  generate
    for (g = 0; g < LAMP_COUNT; g++) begin : g_thermo
      assign thermo[g] = (stepIdx > g);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lampLeft  <= '0;
      lampRight <= '0;
    end else if (strobe.load) begin
      lampLeft  <= (strobe.side == SIDE_LEFT)  ? thermo : '0;
      lampRight <= (strobe.side == SIDE_RIGHT) ? thermo : '0;
    end
  end
endmodule

// File: rtl/turn_signal_ctrl.sv
module turn_signal_ctrl
  import turn_signal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reqLeft,
  input  logic             reqRight,
  output logic [LAMPS-1:0] lampLeft,
  output logic [LAMPS-1:0] lampRight
);
  ctrl_strobe_t       strobe;
  logic [CNT_W-1:0]   stepIdx;

  turn_signal_ctrl_fsm #(.STEP_COUNT(STEPS)) fsm_i (
    .clk(clk), .rst(rst), .reqLeft(reqLeft), .reqRight(reqRight),
    .strobe(strobe), .stepIdx(stepIdx)
  );

  turn_signal_lamp_dp #(.LAMP_COUNT(LAMPS)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .stepIdx(stepIdx),
    .lampLeft(lampLeft), .lampRight(lampRight)
  );
endmodule

// File: rtl/turn_signal_ctrl_chk.sv
module turn_signal_ctrl_chk
  import turn_signal_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reqLeft,
  input logic             reqRight,
  input logic [LAMPS-1:0] lampLeft,
  input logic [LAMPS-1:0] lampRight
);
  logic started = 1'b0;
  always_ff @(posedge clk) if (rst) started <= 1'b1;

  AST_RESET_DARK: assert property (@(posedge clk) rst |=> (lampLeft == '0 && lampRight == '0)); // R1
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst || !started)
    (lampLeft == '0 && lampRight == '0 && !reqLeft && !reqRight) |=> (lampLeft == '0 && lampRight == '0)); // R2
  AST_LEFT_START: assert property (@(posedge clk) disable iff (rst || !started)
    (lampLeft == '0 && lampRight == '0 && reqLeft) |=> (lampLeft == 3'b001 && lampRight == '0)); // R3
  AST_RIGHT_START: assert property (@(posedge clk) disable iff (rst || !started)
    (lampLeft == '0 && lampRight == '0 && !reqLeft && reqRight) |=> (lampRight == 3'b001 && lampLeft == '0)); // R4
  AST_LEFT_RUNS: assert property (@(posedge clk) disable iff (rst || !started)
    (lampLeft == 3'b001) |=> (lampLeft == 3'b011)); // R5
  AST_RIGHT_RUNS: assert property (@(posedge clk) disable iff (rst || !started)
    (lampRight == 3'b011) |=> (lampRight == 3'b111)); // R5
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst || !started)
    !(lampLeft != '0 && lampRight != '0)); // R7
  AST_END_DARK: assert property (@(posedge clk) disable iff (rst || !started)
    (lampLeft == 3'b111 || lampRight == 3'b111) |=> (lampLeft == '0 && lampRight == '0)); // R6
endmodule

bind turn_signal_ctrl turn_signal_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .reqLeft(reqLeft), .reqRight(reqRight),
  .lampLeft(lampLeft), .lampRight(lampRight)
);

// File: tb/turn_signal_ctrl_tb_top.sv
module turn_signal_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqLeft = 1'b0;
  logic reqRight = 1'b0;
  logic [2:0] lampLeft, lampRight;

  always #2.5 clk = ~clk;

  turn_signal_ctrl dut_i (
    .clk(clk), .rst(rst), .reqLeft(reqLeft), .reqRight(reqRight),
    .lampLeft(lampLeft), .lampRight(lampRight)
  );

  int checks = 0;
  int errors = 0;
  logic [5:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  // model of the expected state, from the requirements
  int mSide = 0;  // 0 dark, 1 left, 2 right
  int mStep = 0;

  function automatic logic [2:0] thermo(int s);
    return (s == 1) ? 3'b001 : (s == 2) ? 3'b011 : (s == 3) ? 3'b111 : 3'b000;
  endfunction

  // drive inputs for one cycle, then push what the next edge must show
  task automatic step(input logic r, input logic l, input logic rr, input string tag);
    reqLeft = l; reqRight = rr; rst = r;
    if (r) begin mSide = 0; mStep = 0; end
    else if (mSide == 0) begin
      if (l) begin mSide = 1; mStep = 1; end
      else if (rr) begin mSide = 2; mStep = 1; end
    end else if (mStep == 3) begin mSide = 0; mStep = 0; end
    else mStep++;
    expQ.push_back({(mSide == 1) ? thermo(mStep) : 3'b000, (mSide == 2) ? thermo(mStep) : 3'b000});
    tagQ.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor at falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [5:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({lampLeft, lampRight} !== e) begin
        errors++;
        $display("FAIL %s: got L=%b R=%b expected L=%b R=%b", t, lampLeft, lampRight, e[5:3], e[2:0]);
      end
    end
  end

  initial begin
    #1;
    step(1, 0, 0, "R1 reset");
    step(1, 0, 0, "R1 reset");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R2 idle");
    // single left pulse
    step(0, 1, 0, "R3 left");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R3 left seq");
    // single right pulse
    step(0, 0, 1, "R4 right");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R4 right seq");
    // held left: repeat
    for (int i = 0; i < 9; i++) step(0, 1, 0, "R6 held left");
    step(0, 0, 0, "R6 release");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R6 drain");
    // release mid-sequence, opposite side pressed while running
    step(0, 0, 1, "R5 right start");
    step(0, 1, 0, "R5 left ignored");
    step(0, 1, 1, "R5 both ignored");
    step(0, 0, 0, "R5 finish");
    step(0, 0, 0, "R5 dark");
    // both at once
    step(0, 1, 1, "R7 both");
    for (int i = 0; i < 4; i++) step(0, 0, 1, "R7 left runs");
    step(0, 0, 0, "R7 drain");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R7 drain");
    // reset mid-sequence
    step(0, 1, 0, "R1 pre");
    step(0, 0, 0, "R1 mid");
    step(1, 1, 0, "R1 mid reset");
    step(0, 0, 0, "R2 after reset");
    // input change between edges must not move lamps
    reqLeft = 1'b1; #1;
    checks++;
    if (lampLeft !== 3'b000 || lampRight !== 3'b000) begin
      errors++;
      $display("FAIL R8: got L=%b R=%b expected L=000 R=000", lampLeft, lampRight);
    end
    reqLeft = 1'b0;
    #10;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule